// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Handling

This block keeps an asynchronous DRAM's contents alive. It counts out the distributed refresh interval, asks the access controller for the memory bus with a request/grant handshake, and, once granted, drives the row strobe, column strobe and write strobe through a complete refresh cycle. A refresh is issued only while the controller has closed its row and handed over the bus. Each refresh uses one of two patterns, picked by an input: the column-strobe-first pattern, where the device supplies the row itself, or the row-strobe-only pattern, where the block supplies the row from its own wrapping counter.

After reset the block waits for the power-up pause and then runs an initial burst of refresh cycles. Only after that burst does it report that the memory is ready for normal accesses. If the bus is not granted when refreshes fall due, a limited number of them can queue up. They are issued back to back once the grant arrives.

A sleep request moves the device into self-refresh. First any queued refreshes are drained, then one on-time column-first refresh is issued, and then the column-first pattern is held with the row strobe low. A wake request ends self-refresh. The minimum hold time is observed first, then the longer self-refresh precharge, and then one more on-time refresh before the acknowledge is withdrawn.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are high, ref_req, init_done and sr_ack are low, and row_addr is 0.
- R2: ref_req stays low for at least INIT_WAIT_CYC clock cycles after reset is released.
- R3: After that pause, exactly INIT_REFS refresh cycles are issued in the selected pattern. init_done then rises and stays high, with ref_req low in that cycle.
- R4: ras_n and cas_n are driven low only while ref_gnt is high. No refresh starts while the grant is withheld.
- R5: In a column-first refresh, cas_n falls at least CSU_CYC cycles before ras_n falls and stays low for the whole time ras_n is low. we_n is high at all times.
- R6: When ras_only_sel is 1, cas_n stays high during the refresh and row_addr holds steady while ras_n is low. row_addr advances by one after each row-only refresh and wraps from ROWS-1 to 0. The first row used after reset is 0.
- R7: While running with the grant answered, one refresh is issued every INTERVAL_CYC cycles.
- R8: Refreshes that fall due without a grant accumulate up to MAX_PEND; any more are dropped. When the grant arrives, the accumulated ones are issued back to back, with exactly RP_CYC+CSU_CYC+1 cycles of ras_n high between them.
- R9: On sleep_req, queued refreshes are drained. Then one column-first refresh is issued, whatever ras_only_sel says, and then column-first entry begins. sr_ack rises in the cycle cas_n falls for entry, with ras_n still high, and ras_n falls after it.
- R10: In self-refresh, ras_n stays low for at least SR_MIN_CYC cycles, even if wake_req arrives earlier.
- R11: After wake_req, ras_n stays high for at least RPS_CYC cycles before the next fall. That next fall is a column-first refresh. sr_ack falls only after that refresh's precharge, with both strobes high, and periodic refresh then resumes.
- R12: Every normal refresh holds ras_n low for exactly RAS_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_only_sel | input | 1 | 1 selects row-strobe-only refresh, 0 selects column-first refresh |
| ref_gnt | input | 1 | Bus grant from the access controller |
| sleep_req | input | 1 | Request to enter self-refresh, held until sr_ack rises |
| wake_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Bus request to the access controller |
| init_done | output | 1 | Power-up pause and initial burst complete |
| sr_ack | output | 1 | Self-refresh entered; falls after the post-exit refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Row for row-strobe-only refresh |

## Verification
The assertions assume that the controller raises ref_gnt only in answer to ref_req and keeps it high until ref_req drops. They also assume that sleep_req is held until sr_ack rises and is then released, and that wake_req is given only while sr_ack is high. The stimulus grants through a follower process that copies ref_req one half-cycle later. When it withholds the grant, it does so only while no request is open. It toggles the mode select only between refreshes, and it drives sleep and wake in exactly that order.

// File: rtl/dram_rs_pkg.sv
package dram_rs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } seq_st_t;

  typedef enum logic [2:0] {
    TS_WAIT,
    TS_BURST,
    TS_RUN,
    TS_PRE,
    TS_ENTER,
    TS_SLEEP,
    TS_WAKE,
    TS_POST
  } top_st_t;

endpackage

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
  parameter int PERIOD   = 780,
  parameter int MAX_PEND = 8,
  localparam int CW = $clog2(PERIOD),
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic consume,
  output logic pend_nz
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          tick;

  assign tick = en && (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (clr) begin
      cnt_d  = '0;
      pend_d = '0;
    end else begin
      if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
      if (tick && !consume) begin
        if (pend_q != PW'(MAX_PEND)) pend_d = pend_q + 1'b1;
      end else if (consume && !tick) begin
        if (pend_q != '0) pend_d = pend_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_nz = (pend_q != '0);

endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr #(
  parameter int ROWS = 4096,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);

  logic [ROW_W-1:0] row_d;

  always_comb begin
    row_d = row;
    if (inc) row_d = (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else        row <= row_d;
  end

endmodule

// File: rtl/rs_strobe_seq.sv
module rs_strobe_seq
  import dram_rs_pkg::*;
#(
  parameter int CSU_CYC = 1,
  parameter int RAS_CYC = 3,
  parameter int RP_CYC  = 2,
  parameter int RPS_CYC = 6,
  localparam int M1 = (CSU_CYC > RAS_CYC) ? CSU_CYC : RAS_CYC,
  localparam int M2 = (RP_CYC > RPS_CYC) ? RP_CYC : RPS_CYC,
  localparam int CW = $clog2(((M1 > M2) ? M1 : M2) + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cbr_in,
  input  logic sr_in,
  input  logic sr_exit,
  output logic busy,
  output logic done,
  output logic ro_done,
  output logic holding,
  output logic ras_n,
  output logic cas_n
);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          cbr_q, cbr_d, sr_q, sr_d, slow_q, slow_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cbr_d  = cbr_q;
    sr_d   = sr_q;
    slow_d = slow_q;
    done   = 1'b0;
    lim    = slow_q ? CW'(RPS_CYC - 1) : CW'(RP_CYC - 1);
    case (st_q)
      SQ_IDLE: if (start) begin
        st_d   = SQ_SETUP;
        cnt_d  = '0;
        cbr_d  = cbr_in;
        sr_d   = sr_in;
        slow_d = 1'b0;
      end
      SQ_SETUP: begin
        if (cnt_q == CW'(CSU_CYC - 1)) begin
          st_d  = SQ_ACT;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      SQ_ACT: begin
        if (sr_q) begin
          if (sr_exit) begin
            st_d   = SQ_PRE;
            cnt_d  = '0;
            sr_d   = 1'b0;
            slow_d = 1'b1;
          end
        end else if (cnt_q == CW'(RAS_CYC - 1)) begin
          st_d  = SQ_PRE;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      SQ_PRE: begin
        if (cnt_q == lim) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
          done  = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      cbr_q  <= 1'b1;
      sr_q   <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      cbr_q  <= cbr_d;
      sr_q   <= sr_d;
      slow_q <= slow_d;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign ro_done = done && !cbr_q;
  assign holding = (st_q == SQ_ACT) && sr_q;
  assign ras_n   = (st_q != SQ_ACT);
  assign cas_n   = !(cbr_q && ((st_q == SQ_SETUP) || (st_q == SQ_ACT)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rs_pkg::*;
#(
  parameter int INIT_WAIT_CYC = 10000,
  parameter int INIT_REFS     = 8,
  parameter int INTERVAL_CYC  = 780,
  parameter int MAX_PEND      = 8,
  parameter int ROWS          = 4096,
  parameter int SR_MIN_CYC    = 5000,
  parameter int CSU_CYC       = 1,
  parameter int RAS_CYC       = 3,
  parameter int RP_CYC        = 2,
  parameter int RPS_CYC       = 6,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_sel,
  input  logic             ref_gnt,
  input  logic             sleep_req,
  input  logic             wake_req,
  output logic             ref_req,
  output logic             init_done,
  output logic             sr_ack,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);

  localparam int TMAX = (INIT_WAIT_CYC > SR_MIN_CYC) ? INIT_WAIT_CYC : SR_MIN_CYC;
  localparam int TW   = $clog2(TMAX + INIT_REFS + 1);

  logic          rs_meta, srst_n;
  top_st_t       st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          seq_start, seq_cbr, seq_sr, seq_exit;
  logic          seq_busy, seq_done, seq_ro_done, seq_hold;
  logic          pend_nz, free;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      srst_n  <= rs_meta;
    end
  end

  assign free = ref_gnt && !seq_busy;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    seq_start = 1'b0;
    seq_cbr   = !ras_only_sel;
    seq_sr    = 1'b0;
    seq_exit  = 1'b0;
    case (st_q)
      TS_WAIT: begin
        if (cnt_q == TW'(INIT_WAIT_CYC - 1)) begin
          st_d  = TS_BURST;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      TS_BURST: begin
        if (seq_done) begin
          if (cnt_q == TW'(INIT_REFS - 1)) begin
            st_d  = TS_RUN;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end else if (free) seq_start = 1'b1;
      end
      TS_RUN: begin
        if (free && pend_nz) seq_start = 1'b1;
        else if (free && sleep_req) begin
          seq_start = 1'b1;
          seq_cbr   = 1'b1;
          st_d      = TS_PRE;
        end
      end
      TS_PRE: if (seq_done) st_d = TS_ENTER;
      TS_ENTER: begin
        if (free) begin
          seq_start = 1'b1;
          seq_cbr   = 1'b1;
          seq_sr    = 1'b1;
          st_d      = TS_SLEEP;
          cnt_d     = '0;
        end
      end
      TS_SLEEP: begin
        if (seq_hold) begin
          if (cnt_q != TW'(SR_MIN_CYC)) cnt_d = cnt_q + 1'b1;
          else if (wake_req) begin
            seq_exit = 1'b1;
            st_d     = TS_WAKE;
          end
        end
      end
      TS_WAKE: begin
        if (seq_done) begin
          st_d  = TS_POST;
          cnt_d = '0;
        end
      end
      TS_POST: begin
        if (seq_done) begin
          st_d  = TS_RUN;
          cnt_d = '0;
        end else if (free && (cnt_q == '0)) begin
          seq_start = 1'b1;
          seq_cbr   = 1'b1;
          cnt_d     = TW'(1);
        end
      end
      default: st_d = TS_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= TS_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  rs_tick_gen #(.PERIOD(INTERVAL_CYC), .MAX_PEND(MAX_PEND)) i_tick (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     ((st_q == TS_WAIT) || (st_q == TS_BURST) || (st_q == TS_SLEEP)),
    .en      (st_q == TS_RUN),
    .consume (seq_done && (st_q == TS_RUN)),
    .pend_nz (pend_nz)
  );

  rs_strobe_seq #(.CSU_CYC(CSU_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
                  .RPS_CYC(RPS_CYC)) i_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (seq_start),
    .cbr_in  (seq_cbr),
    .sr_in   (seq_sr),
    .sr_exit (seq_exit),
    .busy    (seq_busy),
    .done    (seq_done),
    .ro_done (seq_ro_done),
    .holding (seq_hold),
    .ras_n   (ras_n),
    .cas_n   (cas_n)
  );

  rs_row_ctr #(.ROWS(ROWS)) i_row (
    .clk   (clk),
    .rst_n (srst_n),
    .inc   (seq_ro_done),
    .row   (row_addr)
  );

  always_comb begin
    case (st_q)
      TS_WAIT: ref_req = 1'b0;
      TS_RUN:  ref_req = pend_nz || sleep_req;
      default: ref_req = 1'b1;
    endcase
  end

  assign init_done = (st_q != TS_WAIT) && (st_q != TS_BURST);
  assign sr_ack    = (st_q == TS_SLEEP) || (st_q == TS_WAKE) || (st_q == TS_POST);
  assign we_n      = 1'b1;

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROWS      = 4096,
  parameter int INIT_REFS = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             init_done,
  input logic             sr_ack,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr
);

  logic [7:0] fall_cnt;
  logic       ras_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= '0;
      ras_prev <= 1'b1;
    end else begin
      ras_prev <= ras_n;
      if (!init_done && ras_prev && !ras_n && (fall_cnt != 8'hFF))
        fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R3: the ready flag rises only after the whole initial burst
  p_init_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (fall_cnt == 8'(INIT_REFS)));

  // R4: strobes are active only under grant
  p_strobe_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_gnt);

  // R5: column strobe low before the row strobe falls in the column-first pattern
  p_cbr_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  // R5: column strobe does not move while the row strobe is low
  p_cas_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> $stable(cas_n));

  // R6: row changes only by one step with wrap
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> ((row_addr == $past(row_addr) + 1'b1) ||
      ((row_addr == '0) && ($past(row_addr) == ROW_W'(ROWS - 1)))));

  // R6: row held while the row strobe is low
  p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> $stable(row_addr));

  // R9: acknowledge rises with the entry column strobe, row strobe still high
  p_ack_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_ack) |-> (!cas_n && ras_n));

  // R11: acknowledge falls with both strobes released
  p_ack_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ack) |-> (cas_n && ras_n));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROWS(ROWS), .INIT_REFS(INIT_REFS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .init_done (init_done),
  .sr_ack    (sr_ack),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .row_addr  (row_addr)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;

  localparam int INIT_WAIT = 40;
  localparam int INIT_REFS = 8;
  localparam int INTERVAL  = 50;
  localparam int MAX_PEND  = 3;
  localparam int ROWS      = 8;
  localparam int SR_MIN    = 30;
  localparam int CSU       = 1;
  localparam int RASC      = 3;
  localparam int RP        = 2;
  localparam int RPS       = 8;
  localparam int RW        = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ras_only_sel, ref_gnt, sleep_req, wake_req;
  logic          ref_req, init_done, sr_ack, ras_n, cas_n, we_n;
  logic [RW-1:0] row_addr;
  logic          auto_gnt;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched #(
    .INIT_WAIT_CYC(INIT_WAIT), .INIT_REFS(INIT_REFS), .INTERVAL_CYC(INTERVAL),
    .MAX_PEND(MAX_PEND), .ROWS(ROWS), .SR_MIN_CYC(SR_MIN), .CSU_CYC(CSU),
    .RAS_CYC(RASC), .RP_CYC(RP), .RPS_CYC(RPS)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ras_only_sel(ras_only_sel), .ref_gnt(ref_gnt),
    .sleep_req(sleep_req), .wake_req(wake_req), .ref_req(ref_req),
    .init_done(init_done), .sr_ack(sr_ack), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row_addr)
  );

  // strobe monitor, samples on the falling clock edge
  int cbr_cnt = 0, ro_cnt = 0;
  int low_len = 0, high_len = 0, last_low = 0, last_gap = 0;
  int setup_err = 0, hold_err = 0, we_err = 0, nogrant_err = 0, row_err = 0;
  int first_ro_row = -1, last_row = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, fall_cas = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) we_err++;
      if ((!ras_n || !cas_n) && !ref_gnt) nogrant_err++;
      if (prev_ras && !ras_n) begin
        last_gap = high_len;
        low_len  = 1;
        fall_cas = cas_n;
        if (!cas_n) begin
          cbr_cnt++;
          if (prev_cas) setup_err++;
        end else begin
          ro_cnt++;
          if (first_ro_row < 0) first_ro_row = int'(row_addr);
          else if (int'(row_addr) != (last_row + 1) % ROWS) row_err++;
          last_row = int'(row_addr);
        end
      end else if (!ras_n) begin
        low_len++;
        if (cas_n != fall_cas) hold_err++;
      end else if (!prev_ras) begin
        last_low = low_len;
        high_len = 1;
      end else high_len++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // grant follower
  initial begin
    ref_gnt = 1'b0;
    forever begin
      @(negedge clk);
      ref_gnt = auto_gnt && ref_req;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_sig(ref logic s, input logic v, input int lim, input string req);
    int n = 0;
    while (s !== v && n < lim) begin
      step();
      n++;
    end
    check(s === v, req, int'(s), int'(v));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ras_only_sel = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    auto_gnt = 1'b0;
    step(3);
    check(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
    check(!ref_req && !init_done && !sr_ack, "R1 flags low",
          {ref_req, init_done, sr_ack}, 0);
    check(row_addr == '0, "R1 row", int'(row_addr), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_init();
    int n = 0;
    while (!ref_req && n < INIT_WAIT + 20) begin
      step();
      n++;
    end
    check(n >= INIT_WAIT && n <= INIT_WAIT + 4, "R2 pause before request", n, INIT_WAIT);
    auto_gnt = 1'b1;
    wait_sig(init_done, 1'b1, 400, "R3 ready flag");
    check(!ref_req, "R3 request dropped", int'(ref_req), 0);
    step();
    check(cbr_cnt == INIT_REFS && ro_cnt == 0, "R3 burst count", cbr_cnt, INIT_REFS);
    check(last_low == RASC, "R12 row strobe width", last_low, RASC);
    check(last_gap == RP + CSU + 1, "R8 burst spacing", last_gap, RP + CSU + 1);
  endtask

  task automatic t_periodic();
    int c0 = cbr_cnt;
    step(10 * INTERVAL);
    check(cbr_cnt - c0 >= 9 && cbr_cnt - c0 <= 11, "R7 periodic rate", cbr_cnt - c0, 10);
    check(setup_err == 0, "R5 column strobe setup", setup_err, 0);
    check(hold_err == 0, "R5 column strobe hold", hold_err, 0);
    check(we_err == 0, "R5 write strobe high", we_err, 0);
    check(last_low == RASC, "R12 periodic width", last_low, RASC);
  endtask

  task automatic t_postpone();
    int c0;
    wait_sig(ref_req, 1'b0, 3 * INTERVAL, "R8 idle before hold-off");
    auto_gnt = 1'b0;
    wait_sig(ref_req, 1'b1, 3 * INTERVAL, "R8 request raised");
    c0 = cbr_cnt;
    step(4 * INTERVAL + 3);
    check(cbr_cnt == c0, "R4 no refresh without grant", cbr_cnt - c0, 0);
    check(ref_req, "R8 request held", int'(ref_req), 1);
    auto_gnt = 1'b1;
    wait_sig(ref_req, 1'b0, 2 * INTERVAL, "R8 drain finished");
    step(2);
    check(cbr_cnt - c0 == MAX_PEND, "R8 capped backlog", cbr_cnt - c0, MAX_PEND);
    check(last_gap == RP + CSU + 1, "R8 back to back", last_gap, RP + CSU + 1);
    check(nogrant_err == 0, "R4 strobes under grant", nogrant_err, 0);
  endtask

  task automatic t_ras_only();
    int c0 = cbr_cnt;
    int r0 = ro_cnt;
    ras_only_sel = 1'b1;
    step(10 * INTERVAL + 10);
    check(ro_cnt - r0 >= 9, "R6 row-only refreshes", ro_cnt - r0, 10);
    check(cbr_cnt == c0, "R6 column strobe stays high", cbr_cnt - c0, 0);
    check(first_ro_row == 0, "R6 first row", first_ro_row, 0);
    check(row_err == 0, "R6 row step and wrap", row_err, 0);
    check(hold_err == 0, "R6 column strobe steady", hold_err, 0);
  endtask

  task automatic t_self_refresh();
    int c0, r0;
    wait_sig(ref_req, 1'b0, 3 * INTERVAL, "R9 idle before sleep");
    c0 = cbr_cnt;
    sleep_req = 1'b1;
    wait_sig(sr_ack, 1'b1, 200, "R9 acknowledge");
    check(!cas_n && ras_n, "R9 entry pattern", {cas_n, ras_n}, 1);
    step();
    check(cbr_cnt - c0 == 1, "R9 one refresh before entry", cbr_cnt - c0, 1);
    sleep_req = 1'b0;
    step(3);
    check(!ras_n && !cas_n, "R9 held in self-refresh", {ras_n, cas_n}, 0);
    step(2);
    wake_req = 1'b1;
    wait_sig(ras_n, 1'b1, 4 * SR_MIN, "R10 exit");
    wake_req = 1'b0;
    step();
    check(last_low >= SR_MIN, "R10 minimum hold", last_low, SR_MIN);
    check(sr_ack, "R11 acknowledge held after exit", int'(sr_ack), 1);
    wait_sig(sr_ack, 1'b0, 200, "R11 acknowledge release");
    check(ras_n && cas_n, "R11 strobes released", {ras_n, cas_n}, 3);
    step();
    check(cbr_cnt - c0 == 3, "R11 refresh after exit", cbr_cnt - c0, 3);
    check(last_gap >= RPS, "R11 long precharge", last_gap, RPS);
    step(2);
    check(!ref_req, "R11 back to idle", int'(ref_req), 0);
    r0 = ro_cnt;
    step(INTERVAL + 10);
    check(ro_cnt - r0 >= 1, "R11 periodic resumes", ro_cnt - r0, 1);
  endtask

  initial begin
    t_reset();
    t_init();
    t_periodic();
    t_postpone();
    t_ras_only();
    t_self_refresh();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule